// File: doc/BRIEF.md
# Multiplexed external bus controller

This block sits between a CPU core with 16-bit addresses and external program and data memory. The two memories share one 8-bit bus that carries the low address first and the data after it. The core issues one request at a time. A request is a fetch, a read or a write, with an address and, for a write, a data byte. The block runs the matching external cycle. For any cycle it drives an address latch enable pulse and puts the upper address byte on its own pins. It then gives a fetch the program strobe, a read the read strobe and a write the write strobe. When the cycle ends it pulses `done_o`, together with the byte for a fetch or a read.

Program space and data space are separate 64K-byte spaces. A fetch whose address lies inside the internal program store never reaches the bus. The block reports it with a one-clock `int_hit_o` pulse instead. The size of the internal store, 16K or 32K bytes, is a parameter.

A hold input lets the core enter a power-down state. The request is granted only between bus cycles, and the grant is shown on `hlda_o`. All timing is counted in clock cycles.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is held and right after it, the strobe outputs are high, `ale_o` is low, `ad_oe_o` is low, `hlda_o` and `done_o` are low, `ready_o` is high and `rdata_o` is 0.
- R2: Fetch (`kind_i`=2'b00) at or above the internal top: the request is accepted on the edge where `req_i` and `ready_o` are both high. `ale_o` is then high for 2 clocks, with AD driving addr[7:0]. Next, `ale_o` is low for 1 clock with the address still driven. Then `psen_no` is low for 3 clocks with AD released. `done_o` follows for one clock.
- R3: Read (`kind_i`=2'b01, and 2'b11 handled the same way) follows the same sequence as R2, using `rd_no` as the strobe. AD is released while `rd_no` is low.
- R4: Write (`kind_i`=2'b10) follows the same address phases, then holds `wr_no` low for 4 clocks. AD is driven with the write byte throughout, and `done_o` follows.
- R5: `a_hi_o` shows addr[15:8] for the whole cycle. At most one strobe is low at a time, and no strobe is low while `ale_o` is high.
- R6: A fetch below the internal top (0x4000 for 16K, 0x8000 for 32K) causes no bus activity. `int_hit_o` pulses one clock after acceptance, `done_o` stays low and `ready_o` stays high.
- R7: `ready_o` is low from the acceptance of an external cycle until its `done_o` clock. Requests made in that window are ignored.
- R8: When `hold_i` is high and the block is idle, `hlda_o` rises one clock later. `ready_o` is low while `hold_i` or `hlda_o` is high. While `hlda_o` is high the bus stays idle and requests are ignored.
- R9: `hlda_o` falls on the first clock edge after `hold_i` falls. `ready_o` returns high only then.
- R10: A hold raised during a cycle lets that cycle finish with `done_o`. `hlda_o` rises on the clock after `done_o`.
- R11: The read byte is sampled from `ad_i` at the edge that ends the last strobe clock, and is presented on `rdata_o` with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| kind_i | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| addr_i | input | 16 | Request address |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Request can be accepted this clock |
| done_o | output | 1 | External cycle finished |
| rdata_o | output | 8 | Fetched or read byte |
| int_hit_o | output | 1 | Fetch resolved internally |
| ale_o | output | 1 | Address latch enable, active high |
| psen_no | output | 1 | Program strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ad_o | output | 8 | Multiplexed address/data out |
| ad_oe_o | output | 1 | Drive enable for AD |
| ad_i | input | 8 | Multiplexed address/data in |
| a_hi_o | output | 8 | Upper address byte |
| hold_i | input | 1 | Power-down request |
| hlda_o | output | 1 | Power-down acknowledge |

## Verification
A phase counter that ends one clock early or late moves a strobe edge or the `done_o` pulse by one clock. Because every pin is compared on every clock of every cycle, that error appears within the first access. A wrong captured kind lowers the wrong strobe or flips the AD direction during the strobe phase of the same cycle. A wrong boundary decode either starts an address phase or drops one on the clock after acceptance. A sampling edge off by one returns the filler byte instead of the data, because the data is on `ad_i` for only the final strobe clock.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_RDALT = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_SETUP = 3'd2,
    ST_STRB  = 3'd3,
    ST_HOLD  = 3'd4
  } state_e;
endpackage

// File: rtl/ebc_rom_decode.sv
module ebc_rom_decode #(
  parameter int AW      = 16,
  parameter int ROM_SEL = 0   // 0: 16K internal, 1: 32K internal
) (
  input  logic [AW-1:0] addr_i,
  output logic          is_int_o
);
  generate
    if (ROM_SEL == 0) begin : g_rom16k
      assign is_int_o = (addr_i[AW-1:14] == '0);
    end else begin : g_rom32k
      assign is_int_o = (addr_i[AW-1:15] == '0);
    end
  endgenerate
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int ALE_CYC     = 2,
  parameter int SETUP_CYC   = 1,
  parameter int RD_STRB_CYC = 3,
  parameter int WR_STRB_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  kind_e         kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          is_int_i,
  input  logic          hold_i,
  input  logic [DW-1:0] ad_i,
  output logic          ready_o,
  output state_e        state_o,
  output kind_e         kind_q_o,
  output logic [AW-1:0] addr_q_o,
  output logic [DW-1:0] wdata_q_o,
  output logic          done_o,
  output logic          int_hit_o,
  output logic [DW-1:0] rdata_o
);
  localparam int MAXC = (WR_STRB_CYC > RD_STRB_CYC) ?
                        ((WR_STRB_CYC > ALE_CYC) ? WR_STRB_CYC : ALE_CYC) :
                        ((RD_STRB_CYC > ALE_CYC) ? RD_STRB_CYC : ALE_CYC);
  localparam int MAXS = (MAXC > SETUP_CYC) ? MAXC : SETUP_CYC;
  localparam int CW   = $clog2(MAXS + 1);
  localparam logic [CW-1:0] ALE_LAST = CW'(ALE_CYC - 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] RD_LAST  = CW'(RD_STRB_CYC - 1);
  localparam logic [CW-1:0] WR_LAST  = CW'(WR_STRB_CYC - 1);

  state_e        state_q;
  kind_e         kind_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [CW-1:0] strb_last;

  assign strb_last = (kind_q == KIND_WRITE) ? WR_LAST : RD_LAST;
  assign ready_o   = (state_q == ST_IDLE) && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= KIND_FETCH;
      cnt_q     <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      done_o    <= 1'b0;
      int_hit_o <= 1'b0;
      rdata_o   <= '0;
    end else begin
      done_o    <= 1'b0;
      int_hit_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hold_i) begin
            state_q <= ST_HOLD;
          end else if (req_i) begin
            if (kind_i == KIND_FETCH && is_int_i) begin
              int_hit_o <= 1'b1;
            end else begin
              state_q <= ST_ADDR;
              cnt_q   <= '0;
              kind_q  <= kind_i;
              addr_q  <= addr_i;
              wdata_q <= wdata_i;
            end
          end
        end
        ST_ADDR: begin
          if (cnt_q == ALE_LAST) begin
            state_q <= ST_SETUP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt_q == SET_LAST) begin
            state_q <= ST_STRB;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STRB: begin
          if (cnt_q == strb_last) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b1;
            if (kind_q != KIND_WRITE) rdata_o <= ad_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!hold_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign kind_q_o  = kind_q;
  assign addr_q_o  = addr_q;
  assign wdata_q_o = wdata_q;

  // R8
  hold_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_HOLD) |-> $past(state_q) == ST_IDLE);
  // R9
  hold_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_HOLD && state_q != ST_HOLD) |-> !$past(hold_i));
  // R2
  done_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q) == ST_STRB);
  // R6
  int_hit_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_hit_o |-> (state_q == ST_IDLE || state_q == ST_HOLD) && !done_o);
endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
  import ebc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  state_e        state_i,
  input  kind_e         kind_i,
  input  logic [DW-1:0] addr_lo_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ale_o,
  output logic          psen_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic          ad_oe_o,
  output logic [DW-1:0] ad_o
);
  logic addr_ph, strb_ph;

  always_comb begin
    addr_ph = (state_i == ST_ADDR) || (state_i == ST_SETUP);
    strb_ph = (state_i == ST_STRB);
    ale_o   = (state_i == ST_ADDR);
    psen_no = !(strb_ph && kind_i == KIND_FETCH);
    wr_no   = !(strb_ph && kind_i == KIND_WRITE);
    rd_no   = !(strb_ph && (kind_i == KIND_READ || kind_i == KIND_RDALT));
    ad_oe_o = addr_ph || (strb_ph && kind_i == KIND_WRITE);
    if (addr_ph)                             ad_o = addr_lo_i;
    else if (strb_ph && kind_i == KIND_WRITE) ad_o = wdata_i;
    else                                      ad_o = '0;
  end

  // R5
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~psen_no, ~rd_no, ~wr_no}) <= 1);
  // R5
  ale_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (psen_no && rd_no && wr_no && ad_oe_o));
  // R3
  read_releases_ad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !psen_no) |-> !ad_oe_o);
  // R4
  write_drives_ad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> ad_oe_o);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int ROM_SEL     = 0,
  parameter int ALE_CYC     = 2,
  parameter int SETUP_CYC   = 1,
  parameter int RD_STRB_CYC = 3,
  parameter int WR_STRB_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          int_hit_o,
  output logic          ale_o,
  output logic          psen_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  input  logic [DW-1:0] ad_i,
  output logic [AW-DW-1:0] a_hi_o,
  input  logic          hold_i,
  output logic          hlda_o
);
  logic          is_int;
  state_e        state;
  kind_e         kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  ebc_rom_decode #(.AW(AW), .ROM_SEL(ROM_SEL)) i_decode (
    .addr_i   (addr_i),
    .is_int_o (is_int)
  );

  ebc_seq #(
    .AW(AW), .DW(DW), .ALE_CYC(ALE_CYC), .SETUP_CYC(SETUP_CYC),
    .RD_STRB_CYC(RD_STRB_CYC), .WR_STRB_CYC(WR_STRB_CYC)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .kind_i    (kind_e'(kind_i)),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .is_int_i  (is_int),
    .hold_i    (hold_i),
    .ad_i      (ad_i),
    .ready_o   (ready_o),
    .state_o   (state),
    .kind_q_o  (kind_q),
    .addr_q_o  (addr_q),
    .wdata_q_o (wdata_q),
    .done_o    (done_o),
    .int_hit_o (int_hit_o),
    .rdata_o   (rdata_o)
  );

  ebc_pins #(.DW(DW)) i_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .kind_i    (kind_q),
    .addr_lo_i (addr_q[DW-1:0]),
    .wdata_i   (wdata_q),
    .ale_o     (ale_o),
    .psen_no   (psen_no),
    .rd_no     (rd_no),
    .wr_no     (wr_no),
    .ad_oe_o   (ad_oe_o),
    .ad_o      (ad_o)
  );

  assign a_hi_o = addr_q[AW-1:DW];
  assign hlda_o = (state == ST_HOLD);

  // R5
  a_hi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psen_no || !rd_no || !wr_no) |-> $stable(a_hi_o));
  // R8
  hold_bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ale_o && psen_no && rd_no && wr_no && !ad_oe_o && !ready_o));
endmodule

// File: tb/test_ext_bus_ctrl.sv
module test_ext_bus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ALE_N = 2;
  localparam int SET_N = 1;
  localparam int RD_S  = 3;
  localparam int WR_S  = 4;
  localparam logic [15:0] ROM_TOP = 16'h4000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [1:0] kind_i = 2'b00;
  logic [15:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] ad_i = '0;
  logic hold_i = 1'b0;
  logic ready_o, done_o, int_hit_o, ale_o, psen_no, rd_no, wr_no, ad_oe_o, hlda_o;
  logic [7:0] rdata_o, ad_o, a_hi_o;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ext_bus_ctrl i_ext_bus_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .kind_i(kind_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .done_o(done_o),
    .rdata_o(rdata_o), .int_hit_o(int_hit_o), .ale_o(ale_o), .psen_no(psen_no),
    .rd_no(rd_no), .wr_no(wr_no), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i),
    .a_hi_o(a_hi_o), .hold_i(hold_i), .hlda_o(hlda_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    n_vec++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " ale"}, ale_o, 1'b0);
    chk({tag, " strobes"}, {psen_no, rd_no, wr_no}, 3'b111);
    chk({tag, " ad_oe"}, ad_oe_o, 1'b0);
  endtask

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic run_access(input logic [1:0] k, input logic [15:0] a, input logic [7:0] wd);
    logic ext;
    int sl, n;
    logic [7:0] dat;
    ext = (k != 2'b00) || (a >= ROM_TOP);
    sl  = (k == 2'b10) ? WR_S : RD_S;
    n   = ALE_N + SET_N + sl + 1;
    dat = mem_byte(a);
    @(negedge clk_i);
    chk("R7 ready before", ready_o, 1'b1);
    chk_idle("R5 idle before");
    req_i = 1'b1; kind_i = k; addr_i = a; wdata_i = wd; ad_i = ~dat;
    if (!ext) begin
      @(negedge clk_i);
      req_i = 1'b0;
      chk("R6 int_hit", int_hit_o, 1'b1);
      chk("R6 done", done_o, 1'b0);
      chk("R6 ready", ready_o, 1'b1);
      chk_idle("R6 bus");
      @(negedge clk_i);
      chk("R6 int_hit end", int_hit_o, 1'b0);
      chk_idle("R6 bus end");
      return;
    end
    for (int s = 1; s <= n; s++) begin
      bit strb;
      @(negedge clk_i);
      strb = (s > ALE_N + SET_N) && (s < n);
      chk("R2 ale", ale_o, (s <= ALE_N));
      chk("R2 psen", psen_no, !(strb && k == 2'b00));
      chk("R3 rd", rd_no, !(strb && k[0]));
      chk("R4 wr", wr_no, !(strb && k == 2'b10));
      chk("R4 ad_oe", ad_oe_o, (s <= ALE_N + SET_N) || (strb && k == 2'b10));
      if (s <= ALE_N + SET_N) chk("R2 ad addr", ad_o, a[7:0]);
      else if (strb && k == 2'b10) chk("R4 ad wdata", ad_o, wd);
      chk("R5 a_hi", a_hi_o, a[15:8]);
      chk("R7 ready", ready_o, (s == n));
      chk("R2 done", done_o, (s == n));
      chk("R6 int_hit ext", int_hit_o, 1'b0);
      if (s == n && k != 2'b10) chk("R11 rdata", rdata_o, dat);
      // R7: a competing request while busy must be ignored
      req_i  = (s < n);
      kind_i = 2'b01;
      addr_i = ~a;
      ad_i   = (s == ALE_N + SET_N + sl) ? dat : ~dat;
    end
    req_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_err++;
      n_vec++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R1 in reset");
    chk("R1 hlda", hlda_o, 1'b0);
    chk("R1 done", done_o, 1'b0);
    chk("R1 rdata", rdata_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready", ready_o, 1'b1);
    chk_idle("R1 after reset");

    // boundary cases
    run_access(2'b00, 16'h3FFF, 8'h00);
    run_access(2'b00, 16'h4000, 8'h00);
    run_access(2'b00, 16'h0000, 8'h00);
    run_access(2'b00, 16'hFFFF, 8'h00);
    run_access(2'b10, 16'h0000, 8'hFF);
    run_access(2'b01, 16'hFFFF, 8'h00);
    // sweep all kinds over a spread of addresses
    for (int i = 0; i < 48; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] a;
        a = 16'(i * 16'h0557) ^ (i[0] ? 16'h3FF0 : 16'h0000);
        run_access(2'(k), a, 8'(i * 37 + k));
      end
    end

    // R8/R9: hold while idle
    @(negedge clk_i);
    hold_i = 1'b1;
    #1;
    chk("R8 ready low on hold", ready_o, 1'b0);
    @(negedge clk_i);
    chk("R8 hlda", hlda_o, 1'b1);
    chk_idle("R8 bus");
    req_i = 1'b1; kind_i = 2'b01; addr_i = 16'h9876;
    @(negedge clk_i);
    chk("R8 req ignored", ale_o, 1'b0);
    chk("R8 hlda held", hlda_o, 1'b1);
    chk("R8 ready", ready_o, 1'b0);
    req_i = 1'b0;
    hold_i = 1'b0;
    #1;
    chk("R9 hlda before edge", hlda_o, 1'b1);
    chk("R9 ready before edge", ready_o, 1'b0);
    @(negedge clk_i);
    chk("R9 hlda drop", hlda_o, 1'b0);
    chk("R9 ready back", ready_o, 1'b1);
    chk_idle("R9 bus");

    // R10: hold raised mid-cycle
    req_i = 1'b1; kind_i = 2'b01; addr_i = 16'h9123; ad_i = 8'h00;
    for (int s = 1; s <= ALE_N + SET_N + RD_S + 2; s++) begin
      @(negedge clk_i);
      req_i = 1'b0;
      if (s == 2) hold_i = 1'b1;
      if (s <= ALE_N + SET_N + RD_S + 1) chk("R10 no early hlda", hlda_o, 1'b0);
      if (s == ALE_N + SET_N + RD_S) chk("R10 strobe", rd_no, 1'b0);
      if (s == ALE_N + SET_N + RD_S + 1) begin
        chk("R10 done", done_o, 1'b1);
        chk("R10 ready", ready_o, 1'b0);
      end
      if (s == ALE_N + SET_N + RD_S + 2) begin
        chk("R10 hlda", hlda_o, 1'b1);
        chk_idle("R10 bus");
      end
    end
    hold_i = 1'b0;
    @(negedge clk_i);
    chk("R10 release", hlda_o, 1'b0);
    run_access(2'b10, 16'hC3A5, 8'h3C);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule